// File: doc/BRIEF.md
# Floating-Point Status CSR File

This block keeps the two pieces of floating-point state that software can see on a RISC-V-style core: the sticky exception flags and the dynamic rounding mode. Software reaches that state through three CSR addresses. One address shows only the flags. One shows only the rounding mode. The third packs both fields into a single control/status word. All three are views of the same two registers.

Every access first passes an enable gate. The core supplies its current floating-point unit status field, and an access made while the unit is off is rejected unless it comes from the debugger. A write that passes the gate raises a one-cycle request to mark the floating-point state dirty. The core uses that request to set its status field to the all-ones value.

Exception flags raised by the arithmetic unit are merged into the stored flags on every clock. Read data, the illegal flag and the dirty request are combinational in the cycle of the access. Stored state changes at the next rising edge.

Top module: `fp_csr_file`

## Requirements
- R1: Reset (rst_n low) clears both the flags and the rounding mode to zero.
- R2: When fs_state is 2'b00 (unit off) and dbg_access is low, a read or write to address 0x001, 0x002 or 0x003 raises csr_illegal. In that case csr_rdata is zero, fs_mark_dirty stays low and no stored field changes.
- R3: With dbg_access high, an access to the three addresses is legal whatever the value of fs_state.
- R4: fs_mark_dirty is high exactly in a cycle with a legal write to one of the three addresses. Reads and rejected writes never raise it.
- R5: The flags view is at address 0x001. A write stores wdata[4:0] and discards every other bit. A read returns the flags in bits [4:0] with zeros above.
- R6: The rounding-mode view is at address 0x002. A write stores wdata[2:0] and discards every other bit. A read returns the mode in bits [2:0] with zeros above. The mode changes only through a legal write.
- R7: The combined view is at address 0x003. It holds the flags in bits [4:0] and the rounding mode in bits [7:5], and reads zero in bits 31..8. A write loads both fields from those positions.
- R8: In every cycle without a legal flags-touching write, the stored flags become their old value ORed with fpu_flags. A flag once set stays set until software writes it.
- R9: A legal write through address 0x001 or 0x003 overrides the fpu_flags merge in the same cycle. A write through 0x002 leaves the merge in effect.
- R10: A read in the same cycle as a write to that view returns the value from before the write.
- R11: Accesses to any other address raise neither csr_illegal nor fs_mark_dirty, return zero and change no stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | CSR address of the access |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| dbg_access | input | 1 | Access comes from the debugger, bypassing the enable gate |
| fs_state | input | 2 | Floating-point unit status field from the core (2'b00 = off) |
| fpu_flags | input | 5 | Exception flags raised by the arithmetic unit this cycle |
| csr_rdata | output | 32 | Read data of the selected view |
| csr_illegal | output | 1 | Access rejected by the enable gate |
| fs_mark_dirty | output | 1 | Request to set the status field to dirty (all ones) |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 5-bit flags field, a 3-bit rounding mode and view addresses 0x001 to 0x003. Because the data word is far wider than the 8 bits the combined view uses, writes with ones in the high bits show that those bits are discarded and read back as zero. The narrow views also cover misplaced bits between fields, for example a rounding-mode write that carries flag-position bits. Since fs_state is a port, every status value, and the debugger bypass, can be set in any cycle alongside a pending merge from fpu_flags.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

    // Which of the three aliased views an address selects
    typedef enum logic [1:0] {
        VIEW_NONE  = 2'd0,
        VIEW_FLAGS = 2'd1,
        VIEW_RMODE = 2'd2,
        VIEW_COMBO = 2'd3
    } fcsr_view_e;

    localparam logic [1:0] FS_OFF = 2'b00;

endpackage

// File: rtl/fcsr_decode.sv
module fcsr_decode
    import fcsr_pkg::*;
#(
    parameter int            ADDR_W     = 12,
    parameter logic [11:0]   FLAGS_ADDR = 12'h001,
    parameter logic [11:0]   RMODE_ADDR = 12'h002,
    parameter logic [11:0]   COMBO_ADDR = 12'h003
) (
    input  logic [ADDR_W-1:0] addr,
    output fcsr_view_e        view
);

    always_comb begin
        if (addr == FLAGS_ADDR[ADDR_W-1:0])
            view = VIEW_FLAGS;
        else if (addr == RMODE_ADDR[ADDR_W-1:0])
            view = VIEW_RMODE;
        else if (addr == COMBO_ADDR[ADDR_W-1:0])
            view = VIEW_COMBO;
        else
            view = VIEW_NONE;
    end

endmodule

// File: rtl/fcsr_gate.sv
module fcsr_gate
    import fcsr_pkg::*;
(
    input  fcsr_view_e view,
    input  logic       rd,
    input  logic       wr,
    input  logic       dbg,
    input  logic [1:0] fs,
    output logic       illegal,
    output logic       wr_ok
);

    logic hit;
    logic unit_on;

    always_comb begin
        hit     = (view != VIEW_NONE);
        unit_on = (fs != FS_OFF) || dbg;
        illegal = hit && (rd || wr) && !unit_on;
        wr_ok   = hit && wr && unit_on;
    end

endmodule

// File: rtl/fcsr_state.sv
module fcsr_state
    import fcsr_pkg::*;
#(
    parameter int FLAG_W = 5,
    parameter int RM_W   = 3,
    localparam int COMBO_W = FLAG_W + RM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  fcsr_view_e         view,
    input  logic               wr_ok,
    input  logic [COMBO_W-1:0] wbits,
    input  logic [FLAG_W-1:0]  raised,
    output logic [FLAG_W-1:0]  flags_q,
    output logic [RM_W-1:0]    rm_q
);

    logic [FLAG_W-1:0] flags_d;
    logic [RM_W-1:0]   rm_d;

    always_comb begin
        flags_d = flags_q | raised;
        rm_d    = rm_q;
        if (wr_ok) begin
            unique case (view)
                VIEW_FLAGS: flags_d = wbits[FLAG_W-1:0];
                VIEW_RMODE: rm_d    = wbits[RM_W-1:0];
                VIEW_COMBO: begin
                    flags_d = wbits[FLAG_W-1:0];
                    rm_d    = wbits[FLAG_W +: RM_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            rm_q    <= '0;
        end else begin
            flags_q <= flags_d;
            rm_q    <= rm_d;
        end
    end

endmodule

// File: rtl/fcsr_rdmux.sv
module fcsr_rdmux
    import fcsr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int FLAG_W = 5,
    parameter int RM_W   = 3
) (
    input  fcsr_view_e        view,
    input  logic              rd,
    input  logic              illegal,
    input  logic [FLAG_W-1:0] flags,
    input  logic [RM_W-1:0]   rm,
    output logic [XLEN-1:0]   rdata
);

    always_comb begin
        rdata = '0;
        if (rd && !illegal) begin
            unique case (view)
                VIEW_FLAGS: rdata[FLAG_W-1:0] = flags;
                VIEW_RMODE: rdata[RM_W-1:0]   = rm;
                VIEW_COMBO: begin
                    rdata[FLAG_W-1:0]   = flags;
                    rdata[FLAG_W +: RM_W] = rm;
                end
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/fp_csr_file.sv
module fp_csr_file
    import fcsr_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          ADDR_W     = 12,
    parameter int          FLAG_W     = 5,
    parameter int          RM_W       = 3,
    parameter logic [11:0] FLAGS_ADDR = 12'h001,
    parameter logic [11:0] RMODE_ADDR = 12'h002,
    parameter logic [11:0] COMBO_ADDR = 12'h003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_rd,
    input  logic              csr_wr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic              dbg_access,
    input  logic [1:0]        fs_state,
    input  logic [FLAG_W-1:0] fpu_flags,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    output logic              fs_mark_dirty
);

    localparam int COMBO_W = FLAG_W + RM_W;

    fcsr_view_e        view;
    logic              wr_ok;
    logic [FLAG_W-1:0] flags_q;
    logic [RM_W-1:0]   rm_q;
    logic              wdata_unused_hi;

    assign wdata_unused_hi = ^csr_wdata[XLEN-1:COMBO_W];

    fcsr_decode #(
        .ADDR_W    (ADDR_W),
        .FLAGS_ADDR(FLAGS_ADDR),
        .RMODE_ADDR(RMODE_ADDR),
        .COMBO_ADDR(COMBO_ADDR)
    ) u_decode (
        .addr(csr_addr),
        .view(view)
    );

    fcsr_gate u_gate (
        .view   (view),
        .rd     (csr_rd),
        .wr     (csr_wr),
        .dbg    (dbg_access),
        .fs     (fs_state),
        .illegal(csr_illegal),
        .wr_ok  (wr_ok)
    );

    fcsr_state #(
        .FLAG_W(FLAG_W),
        .RM_W  (RM_W)
    ) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .view   (view),
        .wr_ok  (wr_ok),
        .wbits  (csr_wdata[COMBO_W-1:0]),
        .raised (fpu_flags),
        .flags_q(flags_q),
        .rm_q   (rm_q)
    );

    fcsr_rdmux #(
        .XLEN  (XLEN),
        .FLAG_W(FLAG_W),
        .RM_W  (RM_W)
    ) u_rdmux (
        .view   (view),
        .rd     (csr_rd),
        .illegal(csr_illegal),
        .flags  (flags_q),
        .rm     (rm_q),
        .rdata  (csr_rdata)
    );

    assign fs_mark_dirty = wr_ok;

endmodule

// File: rtl/fcsr_check.sv
module fcsr_check #(
    parameter int          ADDR_W     = 12,
    parameter int          FLAG_W     = 5,
    parameter int          RM_W       = 3,
    parameter logic [11:0] FLAGS_ADDR = 12'h001,
    parameter logic [11:0] RMODE_ADDR = 12'h002,
    parameter logic [11:0] COMBO_ADDR = 12'h003
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] csr_addr,
    input logic              csr_wr,
    input logic              dbg_access,
    input logic [1:0]        fs_state,
    input logic              csr_illegal,
    input logic              fs_mark_dirty,
    input logic [FLAG_W-1:0] flags_q,
    input logic [RM_W-1:0]   rm_q
);

    logic foreign;
    assign foreign = (csr_addr != FLAGS_ADDR[ADDR_W-1:0]) &&
                     (csr_addr != RMODE_ADDR[ADDR_W-1:0]) &&
                     (csr_addr != COMBO_ADDR[ADDR_W-1:0]);

    // R2: a rejected access never requests dirty
    a_r2_illegal_no_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> !fs_mark_dirty);

    // R2, R3: rejection only with the unit off and no debugger
    a_r3_illegal_needs_off: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (fs_state == 2'b00) && !dbg_access);

    // R4: dirty request only accompanies a write
    a_r4_dirty_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        fs_mark_dirty |-> csr_wr);

    // R6: rounding mode moves only on a legal write
    a_r6_rm_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_mark_dirty |=> $stable(rm_q));

    // R8: without a write, no stored flag is cleared
    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_mark_dirty |=> (($past(flags_q) & ~flags_q) == '0));

    // R11: foreign addresses stay quiet
    a_r11_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        foreign |-> !csr_illegal && !fs_mark_dirty);

endmodule

bind fp_csr_file fcsr_check #(
    .ADDR_W    (ADDR_W),
    .FLAG_W    (FLAG_W),
    .RM_W      (RM_W),
    .FLAGS_ADDR(FLAGS_ADDR),
    .RMODE_ADDR(RMODE_ADDR),
    .COMBO_ADDR(COMBO_ADDR)
) u_fcsr_check (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_addr     (csr_addr),
    .csr_wr       (csr_wr),
    .dbg_access   (dbg_access),
    .fs_state     (fs_state),
    .csr_illegal  (csr_illegal),
    .fs_mark_dirty(fs_mark_dirty),
    .flags_q      (flags_q),
    .rm_q         (rm_q)
);

// File: tb/fp_csr_file_bench.sv
`timescale 1ns/1ps
module fp_csr_file_bench;

    localparam logic [11:0] A_FLG = 12'h001;
    localparam logic [11:0] A_RM  = 12'h002;
    localparam logic [11:0] A_CMB = 12'h003;
    localparam logic [11:0] A_FOR = 12'h300;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] csr_addr;
    logic        csr_rd, csr_wr;
    logic [31:0] csr_wdata;
    logic        dbg_access;
    logic [1:0]  fs_state;
    logic [4:0]  fpu_flags;
    logic [31:0] csr_rdata;
    logic        csr_illegal, fs_mark_dirty;

    logic [31:0] got_rd;
    logic        got_ill, got_dty;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;

    always #2.5 clk = ~clk;

    fp_csr_file u_fp_csr_file (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .dbg_access(dbg_access),
        .fs_state(fs_state), .fpu_flags(fpu_flags), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .fs_mark_dirty(fs_mark_dirty)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One access cycle: drive at falling edge, sample before the rising edge
    task automatic cyc(input logic [11:0] a, input logic r, input logic w,
                       input logic [31:0] d, input logic dbg, input logic [1:0] fs,
                       input logic [4:0] ff);
        @(negedge clk);
        csr_addr = a; csr_rd = r; csr_wr = w; csr_wdata = d;
        dbg_access = dbg; fs_state = fs; fpu_flags = ff;
        #1;
        got_rd = csr_rdata; got_ill = csr_illegal; got_dty = fs_mark_dirty;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        cyc(a, 1, 0, 0, 0, 2'b01, 0);
        chk(tag, got_rd, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 combined after reset", A_CMB, 32'h0);
        chk("R1 no illegal", {31'b0, got_ill}, 0);
    endtask

    task automatic t_flags_view;
        cyc(A_FLG, 0, 1, 32'hFFFF_FF35, 0, 2'b01, 0);
        chk("R4 dirty on flags write", {31'b0, got_dty}, 1);
        rd_chk("R5 flags keep low five bits", A_FLG, 32'h15);
        rd_chk("R5 rounding mode untouched", A_RM, 32'h0);
    endtask

    task automatic t_rmode_view;
        cyc(A_RM, 0, 1, 32'hFFFF_FFFE, 0, 2'b10, 0);
        rd_chk("R6 rounding mode low three bits", A_RM, 32'h6);
        rd_chk("R6 flags untouched", A_FLG, 32'h15);
        rd_chk("R7 combined packing", A_CMB, 32'hD5);
    endtask

    task automatic t_combo;
        cyc(A_CMB, 0, 1, 32'h0000_0F6A, 0, 2'b11, 0);
        rd_chk("R7 combined write, upper bits zero", A_CMB, 32'h6A);
        rd_chk("R7 flags from bits 4..0", A_FLG, 32'h0A);
        rd_chk("R7 mode from bits 7..5", A_RM, 32'h3);
    endtask

    task automatic t_fs_off;
        cyc(A_FLG, 0, 1, 32'h1F, 0, 2'b00, 0);
        chk("R2 write rejected", {31'b0, got_ill}, 1);
        chk("R2 no dirty on rejected write", {31'b0, got_dty}, 0);
        cyc(A_CMB, 1, 0, 0, 0, 2'b00, 0);
        chk("R2 read rejected", {31'b0, got_ill}, 1);
        chk("R2 rejected read data zero", got_rd, 0);
        rd_chk("R2 state unchanged", A_CMB, 32'h6A);
    endtask

    task automatic t_debug;
        cyc(A_RM, 0, 1, 32'h1, 1, 2'b00, 0);
        chk("R3 debugger write legal", {31'b0, got_ill}, 0);
        chk("R3 debugger write dirty", {31'b0, got_dty}, 1);
        cyc(A_CMB, 1, 0, 0, 1, 2'b00, 0);
        chk("R3 debugger read data", got_rd, 32'h2A);
        chk("R4 no dirty on read", {31'b0, got_dty}, 0);
    endtask

    task automatic t_accrue;
        cyc(A_FOR, 0, 0, 0, 0, 2'b01, 5'h10);
        cyc(A_FOR, 0, 0, 0, 0, 2'b01, 5'h01);
        rd_chk("R8 flags accrue", A_FLG, 32'h1B);
    endtask

    task automatic t_priority;
        cyc(A_FLG, 0, 1, 32'h0, 0, 2'b01, 5'h04);
        rd_chk("R9 write beats merge", A_FLG, 32'h0);
        cyc(A_RM, 0, 1, 32'h5, 0, 2'b01, 5'h02);
        rd_chk("R9 mode write keeps merge", A_CMB, 32'hA2);
    endtask

    task automatic t_rdw;
        cyc(A_CMB, 1, 1, 32'h3F, 0, 2'b01, 0);
        chk("R10 read during write sees old", got_rd, 32'hA2);
        rd_chk("R10 new value after write", A_CMB, 32'h3F);
    endtask

    task automatic t_foreign;
        cyc(A_FOR, 1, 1, 32'h0, 0, 2'b00, 0);
        chk("R11 foreign no illegal", {31'b0, got_ill}, 0);
        chk("R11 foreign no dirty", {31'b0, got_dty}, 0);
        chk("R11 foreign read zero", got_rd, 0);
        rd_chk("R11 foreign write no effect", A_CMB, 32'h3F);
    endtask

    initial begin
        rst_n = 0; csr_addr = 0; csr_rd = 0; csr_wr = 0; csr_wdata = 0;
        dbg_access = 0; fs_state = 2'b01; fpu_flags = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_flags_view;
        t_rmode_view;
        t_combo;
        t_fs_off;
        t_debug;
        t_accrue;
        t_priority;
        t_rdw;
        t_foreign;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule